// File: doc/BRIEF.md
# Cascadable Down-Counting Timer Bank

This block holds four 8-bit reload down-counters reached through a byte-addressed register port. Each timer has a mode byte, a reload (base) byte and a read-only count byte. A timer counts pulses of a shared prescaled clock-enable input (`tick`). It can also be slaved to its lower neighbour, so that adjacent timers act as one 16-, 24- or 32-bit counter. When a counter or chain has reached zero, the next pulse reloads it from the base bytes and produces a one-cycle pulse on the underflow output of the topmost timer of the chain.

Each timer runs a three-state machine. `TS_IDLE` means stopped. `TS_HEAD` means counting `tick` as the lowest member of a chain. `TS_LINK` means slaved to the timer below. The transitions are:

- *start*: IDLE or LINK to HEAD, on a legal mode write with count enable set and a non-chained clock select.
- *join*: IDLE to LINK, when a head below starts and absorbs the timer.
- *halt*: HEAD or LINK to IDLE, on a mode write with count enable clear.
- *orphan*: LINK to IDLE, one cycle after the timer below has become idle.

Accesses are checked as they are decoded. An illegal access is dropped and pulses `acc_err`.

Top module: `tmr_bank`

## Requirements
- R1: After reset all mode and base bytes read 0, every timer is idle, and `acc_err`, `rsp_valid` and `uflow` are low.
- R2: Mode byte fields are: bit 7 count enable, bit 6 load, bits 1:0 clock select (11 = chained to the lower timer, any other code counts `tick`), and bits 5:2 reserved. A mode write with any reserved bit set raises `acc_err` and leaves the mode byte unchanged.
- R3: A mode write that sets bits 7 and 6 together raises `acc_err` and is ignored.
- R4: While a timer is idle, its count reads back as its base byte. A base write is therefore visible at once in the count.
- R5: A running chain decrements once per `tick` cycle. On the `tick` that follows a zero count, every member reloads from its base byte and `uflow` pulses for one cycle. A base written during counting takes effect only at that reload.
- R6: A start whose combined reload value is zero leaves the timer idle without error.
- R7: A head at timer n absorbs each consecutive higher timer whose select is 11. The base of timer n+k forms bits 8k+7:8k of the reload value. Only the topmost chain member pulses `uflow`.
- R8: Writing select 11 to timer 0 raises `acc_err` and is ignored.
- R9: Starting a head when an absorbed upper timer has count enable clear raises `acc_err`, and nothing changes.
- R10: The address map is 0x00+i for mode, 0x10+i for base and 0x20+i for count, with i below 4. Any other address, and any write to a count, raises `acc_err`.
- R11: `req_size` 0, 1 and 2 mean 1, 2 and 4 bytes, and 3 is illegal. A 2-byte access needs an even timer index and a 4-byte access needs index 0. The lower-numbered timer goes in the more significant byte, and unused upper bytes read 0. Mode writes must be 1 byte. A violation raises `acc_err`.
- R12: A legal read gives `rsp_valid` high with `rsp_rdata` on the cycle after the request. An erroring access gives `acc_err` on that cycle and no `rsp_valid`.
- R13: A mode write clearing count enable stops the timer, and its count then reads its base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled count enable |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, right-aligned |
| acc_err | output | 1 | Illegal-access pulse |
| uflow | output | 4 | Per-timer underflow pulse |

## Verification
The bench targets the borrow between chained bytes. After three ticks of a 0x0102 chain, the low byte must wrap to FF while the upper byte drops to 00; a design that reloads each byte on its own would show 02 and 01 instead. It also checks that the underflow of a two-timer chain appears only on the upper output, after exactly reload+1 ticks. A design that pulses the head's own output, or reloads one tick early or late, fails that check. Further checks cover rejected mode writes that must leave state untouched, a base change during counting that must wait for the reload, and a zero reload that must not start.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        TS_IDLE = 2'd0,
        TS_HEAD = 2'd1,
        TS_LINK = 2'd2
    } tstate_e;

    typedef enum logic [1:0] {
        RG_MODE = 2'd0,
        RG_BASE = 2'd1,
        RG_CNT  = 2'd2,
        RG_NONE = 2'd3
    } region_e;

    localparam logic [1:0] SEL_CHAIN = 2'b11;
    localparam int         BYTE_W    = 8;
    localparam int         BUS_BYTES = 4;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode #(
    parameter int NUM_TMR = 4,
    localparam int IW = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
    input  logic [7:0]          addr,
    input  logic [1:0]          size,
    output tmr_pkg::region_e    rg,
    output logic [IW-1:0]       idx,
    output logic [2:0]          nb,
    output logic                ok
);
    import tmr_pkg::*;

    always_comb begin
        unique case (addr[7:4])
            4'h0:    rg = RG_MODE;
            4'h1:    rg = RG_BASE;
            4'h2:    rg = RG_CNT;
            default: rg = RG_NONE;
        endcase
        unique case (size)
            2'd0:    nb = 3'd1;
            2'd1:    nb = 3'd2;
            2'd2:    nb = 3'd4;
            default: nb = 3'd0;
        endcase
        idx = addr[IW-1:0];
        ok  = 1'b0;
        if (nb != 3'd0 && rg != RG_NONE && int'(addr[3:0]) < NUM_TMR) begin
            ok = ((int'(idx) % int'(nb)) == 0) && (int'(idx) + int'(nb) <= NUM_TMR);
        end
    end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit #(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_we,
    input  logic [W-1:0]     mode_wd,
    input  logic             base_we,
    input  logic [W-1:0]     base_wd,
    input  logic             go_head,
    input  logic             go_link,
    input  logic             go_stop,
    input  logic             dec,
    input  logic             rld,
    output tmr_pkg::tstate_e st,
    output logic [W-1:0]     cnt,
    output logic [W-1:0]     base,
    output logic [W-1:0]     mode
);
    import tmr_pkg::*;

    tstate_e st_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TS_IDLE;
        else        st <= st_n;
    end

    always_comb begin
        st_n = st;
        unique case (st)
            TS_IDLE: begin
                if (go_head)      st_n = TS_HEAD;   // start
                else if (go_link) st_n = TS_LINK;   // join
            end
            TS_HEAD: begin
                if (go_head)      st_n = TS_HEAD;   // restart
                else if (go_link) st_n = TS_LINK;
                else if (go_stop) st_n = TS_IDLE;   // halt
            end
            TS_LINK: begin
                if (go_head)      st_n = TS_HEAD;   // start
                else if (go_link) st_n = TS_LINK;
                else if (go_stop) st_n = TS_IDLE;   // halt / orphan
            end
            default:              st_n = TS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            base <= '0;
            mode <= '0;
        end else begin
            if (mode_we) mode <= mode_wd;
            if (base_we) base <= base_wd;
            if (go_head || go_link) cnt <= base;
            else if (rld)           cnt <= base;
            else if (dec)           cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank #(
    parameter int NUM_TMR = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [7:0]         req_addr,
    input  logic [1:0]         req_size,
    input  logic [31:0]        req_wdata,
    output logic               rsp_valid,
    output logic [31:0]        rsp_rdata,
    output logic               acc_err,
    output logic [NUM_TMR-1:0] uflow
);
    import tmr_pkg::*;

    localparam int IW = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1;
    localparam int W  = BYTE_W;
    localparam int DW = BYTE_W * BUS_BYTES;

    region_e       rg;
    logic [IW-1:0] idx;
    logic [2:0]    nb;
    logic          dec_ok;

    tstate_e       st_a   [NUM_TMR];
    logic [W-1:0]  cnt_a  [NUM_TMR];
    logic [W-1:0]  base_a [NUM_TMR];
    logic [W-1:0]  mode_a [NUM_TMR];
    logic [W-1:0]  base_wd[NUM_TMR];

    logic [NUM_TMR-1:0] mode_we, base_we, go_head, go_link, go_stop_w, stop_all;
    logic [NUM_TMR-1:0] dec_v, rld_v, uf_n, absorb;
    logic               bad, rd_ok;
    logic [DW-1:0]      rdata_n;

    tmr_decode #(.NUM_TMR(NUM_TMR)) u_dec (
        .addr(req_addr), .size(req_size),
        .rg(rg), .idx(idx), .nb(nb), .ok(dec_ok)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_TMR; g++) begin : g_unit
            tmr_unit #(.W(W)) u_tmr (
                .clk(clk), .rst_n(rst_n),
                .mode_we(mode_we[g]), .mode_wd(req_wdata[W-1:0]),
                .base_we(base_we[g]), .base_wd(base_wd[g]),
                .go_head(go_head[g]), .go_link(go_link[g]), .go_stop(stop_all[g]),
                .dec(dec_v[g]), .rld(rld_v[g]),
                .st(st_a[g]), .cnt(cnt_a[g]), .base(base_a[g]), .mode(mode_a[g])
            );
        end
    endgenerate

    // Access decode, legality and mode-write chain scan
    always_comb begin
        logic [W-1:0] wd;
        logic         cont, nz, chain_bad;
        mode_we   = '0;
        base_we   = '0;
        go_head   = '0;
        go_link   = '0;
        go_stop_w = '0;
        absorb    = '0;
        bad       = 1'b0;
        rd_ok     = 1'b0;
        wd        = req_wdata[W-1:0];
        cont      = 1'b1;
        nz        = 1'b0;
        chain_bad = 1'b0;
        for (int i = 0; i < NUM_TMR; i++) base_wd[i] = '0;
        if (req_valid) begin
            if (!dec_ok) begin
                bad = 1'b1;
            end else if (!req_write) begin
                rd_ok = 1'b1;
            end else begin
                unique case (rg)
                    RG_BASE: begin
                        for (int k = 0; k < NUM_TMR; k++) begin
                            if (k >= int'(idx) && k < int'(idx) + int'(nb)) begin
                                base_we[k] = 1'b1;
                                base_wd[k] = req_wdata[(int'(nb) - 1 - (k - int'(idx))) * W +: W];
                            end
                        end
                    end
                    RG_MODE: begin
                        if (nb != 3'd1 || wd[5:2] != '0 || (wd[7] && wd[6]) ||
                            (idx == '0 && wd[1:0] == SEL_CHAIN)) begin
                            bad = 1'b1;
                        end else begin
                            nz = (base_a[idx] != '0);
                            for (int j = 0; j < NUM_TMR; j++) begin
                                if (j > int'(idx) && cont) begin
                                    if (mode_a[j][1:0] == SEL_CHAIN) begin
                                        absorb[j] = 1'b1;
                                        if (!mode_a[j][7]) chain_bad = 1'b1;
                                        if (base_a[j] != '0) nz = 1'b1;
                                    end else begin
                                        cont = 1'b0;
                                    end
                                end
                            end
                            if (wd[7] && wd[1:0] != SEL_CHAIN) begin
                                if (chain_bad) begin
                                    bad = 1'b1;
                                end else begin
                                    mode_we[idx] = 1'b1;
                                    if (nz) begin
                                        go_head[idx] = 1'b1;
                                        go_link      = absorb;
                                    end else begin
                                        go_stop_w[idx] = 1'b1;
                                    end
                                end
                            end else begin
                                mode_we[idx] = 1'b1;
                                if (!wd[7] || st_a[idx] == TS_HEAD) go_stop_w[idx] = 1'b1;
                            end
                        end
                    end
                    default: bad = 1'b1;   // count region is read-only
                endcase
            end
        end
    end

    // Borrow / reload chain and orphaned-link detection
    always_comb begin
        logic [NUM_TMR:0] lk, zab, dx, rx, czx, ib;
        lk  = '0;
        zab = '0;
        dx  = '0;
        rx  = '0;
        czx = '0;
        ib  = '0;
        zab[NUM_TMR] = 1'b1;
        ib[0]        = 1'b1;
        for (int i = 0; i < NUM_TMR; i++) begin
            lk[i]    = (st_a[i] == TS_LINK);
            ib[i+1]  = (st_a[i] == TS_IDLE);
            czx[i+1] = (cnt_a[i] == '0);
        end
        for (int i = NUM_TMR - 1; i >= 0; i--) begin
            zab[i] = (cnt_a[i] == '0) && (!lk[i+1] || zab[i+1]);
        end
        dec_v    = '0;
        rld_v    = '0;
        uf_n     = '0;
        stop_all = go_stop_w;
        for (int i = 0; i < NUM_TMR; i++) begin
            unique case (st_a[i])
                TS_HEAD: begin
                    dec_v[i] = tick && !zab[i];
                    rld_v[i] = tick && zab[i];
                end
                TS_LINK: begin
                    dec_v[i] = dx[i] && czx[i];
                    rld_v[i] = rx[i];
                    if (ib[i] && !go_link[i]) stop_all[i] = 1'b1;
                end
                default: ;
            endcase
            dx[i+1] = dec_v[i];
            rx[i+1] = rld_v[i];
            uf_n[i] = rld_v[i] && !lk[i+1];
        end
    end

    // Read data assembly, lower timer in the more significant byte
    always_comb begin
        logic [W-1:0] b;
        rdata_n = '0;
        for (int k = 0; k < NUM_TMR; k++) begin
            if (k >= int'(idx) && k < int'(idx) + int'(nb)) begin
                unique case (rg)
                    RG_MODE: b = mode_a[k];
                    RG_BASE: b = base_a[k];
                    RG_CNT:  b = (st_a[k] == TS_IDLE) ? base_a[k] : cnt_a[k];
                    default: b = '0;
                endcase
                rdata_n[(int'(nb) - 1 - (k - int'(idx))) * W +: W] = b;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            acc_err   <= 1'b0;
            uflow     <= '0;
        end else begin
            rsp_valid <= rd_ok;
            rsp_rdata <= rd_ok ? rdata_n : '0;
            acc_err   <= bad;
            uflow     <= uf_n;
        end
    end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
    parameter int NUM_TMR = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic [7:0]         req_addr,
    input logic [1:0]         req_size,
    input logic               rsp_valid,
    input logic               acc_err,
    input logic [NUM_TMR-1:0] uflow,
    input tmr_pkg::tstate_e   st_a   [NUM_TMR],
    input logic [7:0]         mode_a [NUM_TMR]
);
    import tmr_pkg::*;

    AST_T0_NEVER_CHAINED: assert property (@(posedge clk) disable iff (!rst_n)
        mode_a[0][1:0] != SEL_CHAIN); // R8

    AST_CNT_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr[7:4] == 4'h2) |=> acc_err); // R10

    AST_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd3) |=> acc_err); // R11

    AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> !rsp_valid); // R12

    genvar i;
    generate
        for (i = 0; i < NUM_TMR; i++) begin : g_t
            AST_RSV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                mode_a[i][5:2] == 4'h0); // R2
            AST_NO_CE_LD: assert property (@(posedge clk) disable iff (!rst_n)
                !(mode_a[i][7] && mode_a[i][6])); // R3
            AST_UFLOW_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
                uflow[i] |-> $past(st_a[i]) != TS_IDLE); // R5
        end
        for (i = 0; i < NUM_TMR - 1; i++) begin : g_top
            AST_UFLOW_TOP: assert property (@(posedge clk) disable iff (!rst_n)
                uflow[i] |-> $past(st_a[i+1]) != TS_LINK); // R7
        end
    endgenerate
endmodule

bind tmr_bank tmr_bank_chk #(.NUM_TMR(NUM_TMR)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .rsp_valid(rsp_valid),
    .acc_err(acc_err), .uflow(uflow), .st_a(st_a), .mode_a(mode_a)
);

// File: tb/tmr_bank_test.sv
module tmr_bank_test;
    localparam int NT = 4;

    logic          clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]    req_addr = '0;
    logic [1:0]    req_size = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid, acc_err;
    logic [31:0]   rsp_rdata;
    logic [NT-1:0] uflow;

    tmr_bank #(.NUM_TMR(NT)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .acc_err(acc_err), .uflow(uflow)
    );

    always #4 clk = ~clk;   // 125 MHz

    int checks = 0, fails = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [7:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, output logic e, output logic v,
                          output logic [31:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        e = acc_err; v = rsp_valid; rd = rsp_rdata;
    endtask

    task automatic wr_ok(input string tag, input logic [7:0] a, input logic [1:0] sz,
                         input logic [31:0] wd, input logic exp_err);
        logic e, v; logic [31:0] rd;
        access(1'b1, a, sz, wd, e, v, rd);
        chk({tag, " write err"}, 32'(e), 32'(exp_err));
    endtask

    task automatic rd_exp(input string tag, input logic [7:0] a, input logic [1:0] sz,
                          input logic [31:0] exp);
        logic e, v; logic [31:0] rd;
        access(1'b0, a, sz, 32'h0, e, v, rd);
        chk({tag, " R12 valid"}, 32'({e, v}), 32'(2'b01));
        chk({tag, " data"}, rd, exp);
    endtask

    task automatic do_tick(output logic [NT-1:0] uf);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        uf = uflow;
    endtask

    typedef struct packed {
        logic        wr;
        logic [7:0]  a;
        logic [1:0]  sz;
        logic [31:0] d;
        logic        e;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VT [NV] = '{
        '{1'b0, 8'h00, 2'd2, 32'h0,        1'b0, 8'd1},  // R1 modes zero
        '{1'b0, 8'h10, 2'd2, 32'h0,        1'b0, 8'd1},  // R1 bases zero
        '{1'b1, 8'h10, 2'd0, 32'h11,       1'b0, 8'd4},  // R4
        '{1'b1, 8'h11, 2'd0, 32'h22,       1'b0, 8'd4},
        '{1'b1, 8'h12, 2'd1, 32'h3344,     1'b0, 8'd11}, // R11 2-byte write
        '{1'b0, 8'h10, 2'd2, 32'h11223344, 1'b0, 8'd11},
        '{1'b0, 8'h12, 2'd1, 32'h3344,     1'b0, 8'd11},
        '{1'b0, 8'h21, 2'd0, 32'h22,       1'b0, 8'd4},  // idle count = base
        '{1'b0, 8'h20, 2'd2, 32'h11223344, 1'b0, 8'd4},
        '{1'b1, 8'h11, 2'd1, 32'h0,        1'b1, 8'd11}, // odd 2-byte
        '{1'b0, 8'h12, 2'd2, 32'h0,        1'b1, 8'd11}, // 4-byte at 2
        '{1'b0, 8'h10, 2'd3, 32'h0,        1'b1, 8'd11}, // size code 3
        '{1'b1, 8'h20, 2'd0, 32'h55,       1'b1, 8'd10}, // R10 count write
        '{1'b0, 8'h30, 2'd0, 32'h0,        1'b1, 8'd10}, // unmapped
        '{1'b0, 8'h14, 2'd0, 32'h0,        1'b1, 8'd10},
        '{1'b1, 8'h00, 2'd0, 32'h04,       1'b1, 8'd2},  // R2 reserved bit
        '{1'b1, 8'h01, 2'd0, 32'hC0,       1'b1, 8'd3},  // R3 CE+load
        '{1'b1, 8'h00, 2'd0, 32'h03,       1'b1, 8'd8},  // R8 timer0 chained
        '{1'b1, 8'h00, 2'd1, 32'h0,        1'b1, 8'd11}, // multi-byte mode write
        '{1'b0, 8'h00, 2'd2, 32'h0,        1'b0, 8'd2},  // rejected writes left no trace
        '{1'b1, 8'h02, 2'd0, 32'h01,       1'b0, 8'd2},
        '{1'b0, 8'h00, 2'd2, 32'h00000100, 1'b0, 8'd2},
        '{1'b1, 8'h02, 2'd0, 32'h00,       1'b0, 8'd2},
        '{1'b1, 8'h10, 2'd2, 32'hAABBCCDD, 1'b0, 8'd11},
        '{1'b0, 8'h20, 2'd2, 32'hAABBCCDD, 1'b0, 8'd4},
        '{1'b0, 8'h22, 2'd0, 32'hCC,       1'b0, 8'd4}
    };

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic e, v;
        logic [31:0] rd;
        logic [NT-1:0] uf, uf_acc;
        int n0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset outputs", {29'h0, acc_err, rsp_valid, |uflow}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            access(VT[i].wr, VT[i].a, VT[i].sz, VT[i].d, e, v, rd);
            chk($sformatf("R%0d vec%0d err", VT[i].rq, i), 32'(e), 32'(VT[i].e));
            if (!VT[i].wr && !VT[i].e) begin
                chk($sformatf("R12 vec%0d valid", i), 32'(v), 32'h1);
                chk($sformatf("R%0d vec%0d data", VT[i].rq, i), rd, VT[i].d);
            end
        end

        // R5: single timer, reload 3, period 4 ticks
        wr_ok("R5 base0", 8'h10, 2'd0, 32'h03, 1'b0);
        wr_ok("R5 start0", 8'h00, 2'd0, 32'h80, 1'b0);
        rd_exp("R5 cnt start", 8'h20, 2'd0, 32'h03);
        uf_acc = '0;
        for (int t = 0; t < 3; t++) begin do_tick(uf); uf_acc |= uf; end
        chk("R5 no early uflow", 32'(uf_acc), 32'h0);
        rd_exp("R5 cnt zero", 8'h20, 2'd0, 32'h00);
        do_tick(uf);
        chk("R5 uflow on tick after zero", 32'(uf), 32'h1);
        @(negedge clk);
        chk("R5 single-cycle pulse", 32'(uflow), 32'h0);
        rd_exp("R5 reloaded", 8'h20, 2'd0, 32'h03);

        // R5: base write during counting waits for reload
        do_tick(uf);
        wr_ok("R5 base0 running", 8'h10, 2'd0, 32'h05, 1'b0);
        rd_exp("R5 cnt unaffected", 8'h20, 2'd0, 32'h02);
        uf_acc = '0;
        for (int t = 0; t < 2; t++) begin do_tick(uf); uf_acc |= uf; end
        chk("R5 no uflow before zero", 32'(uf_acc), 32'h0);
        do_tick(uf);
        chk("R5 uflow after base change", 32'(uf), 32'h1);
        rd_exp("R5 new base loaded", 8'h20, 2'd0, 32'h05);

        // R13: stopping returns count to base
        do_tick(uf);
        rd_exp("R13 running cnt", 8'h20, 2'd0, 32'h04);
        wr_ok("R13 stop0", 8'h00, 2'd0, 32'h00, 1'b0);
        rd_exp("R13 stopped cnt reads base", 8'h20, 2'd0, 32'h05);
        do_tick(uf);
        chk("R13 stopped no uflow", 32'(uf), 32'h0);
        wr_ok("R4 base0 idle", 8'h10, 2'd0, 32'h07, 1'b0);
        rd_exp("R4 idle cnt follows base", 8'h20, 2'd0, 32'h07);

        // R7: chain timer0+timer1, reload 0x0102
        wr_ok("R7 bases", 8'h10, 2'd1, 32'h0201, 1'b0);
        wr_ok("R7 mode1 chained", 8'h01, 2'd0, 32'h83, 1'b0);
        rd_exp("R7 idle pair", 8'h20, 2'd1, 32'h0201);
        wr_ok("R7 start head", 8'h00, 2'd0, 32'h80, 1'b0);
        uf_acc = '0;
        for (int t = 0; t < 3; t++) begin do_tick(uf); uf_acc |= uf; end
        rd_exp("R7 borrow wraps low byte", 8'h20, 2'd1, 32'hFF00);
        n0 = 0;
        for (int t = 0; t < 255; t++) begin do_tick(uf); uf_acc |= uf; end
        chk("R7 no uflow before chain zero", 32'(uf_acc), 32'h0);
        do_tick(uf);
        chk("R7 uflow only on top timer", 32'(uf), 32'h2);
        rd_exp("R7 chain reloaded", 8'h20, 2'd1, 32'h0201);
        wr_ok("R7 stop head", 8'h00, 2'd0, 32'h00, 1'b0);
        wr_ok("R7 stop link", 8'h01, 2'd0, 32'h00, 1'b0);

        // R9: absorbed upper without count enable
        wr_ok("R9 mode3 chained off", 8'h03, 2'd0, 32'h03, 1'b0);
        wr_ok("R9 start2 rejected", 8'h02, 2'd0, 32'h80, 1'b1);
        rd_exp("R9 mode2 unchanged", 8'h02, 2'd0, 32'h00);
        do_tick(uf);
        chk("R9 nothing runs", 32'(uf), 32'h0);
        rd_exp("R9 cnt2 idle", 8'h22, 2'd0, 32'hCC);

        // R7: chain timer2+timer3, reload 0xDDCC
        wr_ok("R7 mode3 chained on", 8'h03, 2'd0, 32'h83, 1'b0);
        wr_ok("R7 start2", 8'h02, 2'd0, 32'h80, 1'b0);
        do_tick(uf);
        rd_exp("R7 upper pair counts", 8'h22, 2'd1, 32'hCBDD);
        wr_ok("R7 stop2", 8'h02, 2'd0, 32'h00, 1'b0);
        wr_ok("R7 stop3", 8'h03, 2'd0, 32'h00, 1'b0);

        // R6: zero reload does not start
        wr_ok("R6 base3 zero", 8'h13, 2'd0, 32'h00, 1'b0);
        wr_ok("R6 start3", 8'h03, 2'd0, 32'h80, 1'b0);
        rd_exp("R6 mode stored", 8'h03, 2'd0, 32'h80);
        do_tick(uf);
        chk("R6 no uflow", 32'(uf), 32'h0);
        rd_exp("R6 cnt3", 8'h23, 2'd0, 32'h00);

        // R1: reset while running
        wr_ok("R1 base0", 8'h10, 2'd0, 32'h07, 1'b0);
        wr_ok("R1 start0", 8'h00, 2'd0, 32'h80, 1'b0);
        do_tick(uf);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd_exp("R1 modes after reset", 8'h00, 2'd2, 32'h0);
        rd_exp("R1 counts after reset", 8'h20, 2'd2, 32'h0);
        do_tick(uf);
        chk("R1 idle after reset", 32'(uf), 32'h0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule